// File: doc/BRIEF.md
# Accumulator Machine Control Sequencer

This block is the hardwired timing and control unit of a 16-bit single-accumulator processor with a 12-bit address space, together with the registers it steers: program counter, address register, instruction register, data register, the indirect flag, the accumulator with its extend bit, and a run flip-flop. A 4-bit step counter is decoded into one-hot timing steps. Each register transfer of an instruction is tied to a fixed step. The final step of every instruction clears the counter, so the next fetch begins at step 0.

The unit fetches, decodes and resolves one level of indirection. It then executes the memory-reference instructions and the register-reference instructions. It drives a word-addressed memory that reads combinationally within the clock and writes at the clock edge, so every access fits in one step. Because of this the memory port has no valid/ready handshake, and no back-pressure can occur. Words of the input-output class are decoded and retired as no-ops, because their function belongs to a separate block.

Top module: `acc_seq_core`

## Requirements
- R1: While `rst_n` is low, the unit holds PC=0, step=0, run=1 and `mem_we`=0. After release, the first instruction fetched comes from address 0.
- R2: An instruction word holds the indirect flag in bit 15, the opcode in bits 14..12 and the address in bits 11..0. Opcodes 0..6 are memory-reference. Opcode 7 with bit 15 clear is register-reference. Opcode 7 with bit 15 set is input-output; it ends at step 3 and changes no register other than PC, which has already advanced.
- R3: At step 0, AR takes PC. At step 1, IR takes the word at AR and PC advances by 1. At step 2, AR takes IR[11:0] and the flag takes IR[15]. A direct LDA therefore runs steps 0,1,2,3,4,5 and then returns to 0.
- R4: For a memory-reference instruction with bit 15 set, step 3 loads AR from the low 12 bits of the word at AR.
- R5: AND (opcode 0) gives AC = AC & M. ADD (opcode 1) gives {E,AC} = AC + M, with the carry-out in E. LDA (opcode 2) gives AC = M. In each case DR is read at step 4 and AC is updated at step 5.
- R6: STA (3) writes AC to M[AR] at step 4. BUN (4) loads PC from AR at step 4. BSA (5) writes PC to M[AR] and increments AR at step 4, then loads PC from AR at step 5.
- R7: ISZ (6) reads the word at step 4, increments it at step 5 and writes it back at step 6. If the result is zero, PC is incremented at step 6.
- R8: Register-reference bits act at step 3: bit 11 clears AC (0x7800), bit 10 clears E (0x7400), bit 9 complements AC (0x7200), bit 8 complements E (0x7100), bit 7 rotates {AC,E} right with E entering AC[15] and AC[0] going to E (0x7080), bit 6 rotates left with E entering AC[0] and AC[15] going to E (0x7040), and bit 5 increments AC without touching E (0x7020). 0x7000 changes nothing.
- R9: At step 3, PC is incremented for bit 4 when AC[15]=0 (0x7010), for bit 3 when AC[15]=1 (0x7008), for bit 2 when AC=0 (0x7004), and for bit 1 when E=0 (0x7002).
- R10: Bit 0 (0x7001) clears the run flip-flop. While the run flip-flop is clear, step and PC are frozen and no memory write occurs.
- R11: The step number never exceeds 6. `mem_we` is asserted only at step 4 or step 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Memory word address (AR) |
| mem_rdata | input | 16 | Combinational read data at `mem_addr` |
| mem_wdata | output | 16 | Write data |
| mem_we | output | 1 | Write strobe, taken at the clock edge |
| pc_o | output | 12 | Program counter |
| ac_o | output | 16 | Accumulator |
| e_o | output | 1 | Extend (carry) bit |
| step_o | output | 4 | Current timing step |
| running_o | output | 1 | Run flip-flop |

## Verification
A wrong step or a wrong decode shows up in the instruction's own step: the `mem_addr` driven during the following step is wrong, or a write strobe appears outside steps 4 and 6. A wrong AC or E stays hidden until a later instruction uses it, or until the halt. For that reason every program ends in a halt, and the final PC tells which skips were taken. A missed or extra skip moves the program onto a guard halt placed on purpose, so the stopping PC differs by one or more words as soon as the run flip-flop falls.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;
  typedef enum logic [2:0] {
    OPC_AND = 3'd0,
    OPC_ADD = 3'd1,
    OPC_LDA = 3'd2,
    OPC_STA = 3'd3,
    OPC_BUN = 3'd4,
    OPC_BSA = 3'd5,
    OPC_ISZ = 3'd6,
    OPC_SYS = 3'd7
  } opcode_e;

  localparam int OPC_COUNT = 8;
  localparam int LAST_STEP = 6;

  // register-reference bit positions (behaviour depends on them)
  localparam int RB_CLR_AC = 11;
  localparam int RB_CLR_E  = 10;
  localparam int RB_INV_AC = 9;
  localparam int RB_INV_E  = 8;
  localparam int RB_ROT_R  = 7;
  localparam int RB_ROT_L  = 6;
  localparam int RB_INC_AC = 5;
  localparam int RB_SK_POS = 4;
  localparam int RB_SK_NEG = 3;
  localparam int RB_SK_ZAC = 2;
  localparam int RB_SK_ZE  = 1;
  localparam int RB_STOP   = 0;
endpackage

// File: rtl/acc_seq_timing.sv
module acc_seq_timing #(
  parameter int SC_W   = 4,
  parameter int NSTEPS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  output logic [SC_W-1:0]   sc,
  output logic [NSTEPS-1:0] tstep
);
  localparam logic [SC_W-1:0] SC_ONE = {{(SC_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n)     sc <= '0;
    else if (run) begin
      if (clr)      sc <= '0;
      else          sc <= sc + SC_ONE;
    end
  end

  for (genvar g = 0; g < NSTEPS; g++) begin : g_step
    assign tstep[g] = run && (sc == SC_W'(g));
  end
endmodule

// File: rtl/acc_seq_decode.sv
module acc_seq_decode #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic [DATA_W-1:0] ir,
  input  logic              ind,
  output logic [7:0]        opd,
  output logic              is_mref,
  output logic              is_rref,
  output logic              is_io
);
  localparam int OPC_LSB = ADDR_W;

  for (genvar g = 0; g < acc_seq_pkg::OPC_COUNT; g++) begin : g_opc
    assign opd[g] = (ir[OPC_LSB+2:OPC_LSB] == 3'(g));
  end

  assign is_mref = !opd[acc_seq_pkg::OPC_SYS];
  assign is_rref =  opd[acc_seq_pkg::OPC_SYS] && !ind;
  assign is_io   =  opd[acc_seq_pkg::OPC_SYS] &&  ind;

  logic unused_ok;
  assign unused_ok = &{1'b0, ir[ADDR_W-1:0], ir[DATA_W-1]};
endmodule

// File: rtl/acc_seq_acc.sv
module acc_seq_acc #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_and,
  input  logic              do_add,
  input  logic              do_lda,
  input  logic              rr_en,
  input  logic              clr_ac,
  input  logic              clr_e,
  input  logic              inv_ac,
  input  logic              inv_e,
  input  logic              rot_r,
  input  logic              rot_l,
  input  logic              inc_ac,
  input  logic [DATA_W-1:0] dr,
  output logic [DATA_W-1:0] ac,
  output logic              e
);
  localparam logic [DATA_W-1:0] ONE_D = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] ac_n;
  logic              e_n;
  logic [DATA_W:0]   sum;

  assign sum = {1'b0, ac} + {1'b0, dr};

  always_comb begin
    ac_n = ac;
    e_n  = e;
    if (do_and)      ac_n = ac & dr;
    else if (do_add) {e_n, ac_n} = sum;
    else if (do_lda) ac_n = dr;
    else if (rr_en) begin
      if (clr_ac)      ac_n = '0;
      else if (inv_ac) ac_n = ~ac;
      else if (rot_r)  ac_n = {e, ac[DATA_W-1:1]};
      else if (rot_l)  ac_n = {ac[DATA_W-2:0], e};
      else if (inc_ac) ac_n = ac + ONE_D;
      if (clr_e)       e_n = 1'b0;
      else if (inv_e)  e_n = ~e;
      else if (rot_r)  e_n = ac[0];
      else if (rot_l)  e_n = ac[DATA_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac <= '0;
      e  <= 1'b0;
    end else begin
      ac <= ac_n;
      e  <= e_n;
    end
  end
endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int SC_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] ac_o,
  output logic              e_o,
  output logic [SC_W-1:0]   step_o,
  output logic              running_o
);
  import acc_seq_pkg::*;

  localparam int NSTEPS = LAST_STEP + 1;
  localparam int IND_BIT = DATA_W - 1;
  localparam logic [ADDR_W-1:0] ONE_A = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] ONE_D = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] pc, ar;
  logic [DATA_W-1:0] ir, dr, ac;
  logic              ind, run, e;
  logic [SC_W-1:0]   sc;
  logic [NSTEPS-1:0] t;
  logic [7:0]        opd;
  logic              is_mref, is_rref, is_io;

  // step-qualified controls
  logic ind_ld, rr, io, rd_dr, sta_wr, bun4, bsa4, bsa5, isz5, isz6;
  logic acop5, clr_sc, skip, stop;

  acc_seq_timing #(.SC_W(SC_W), .NSTEPS(NSTEPS)) timing_i (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(clr_sc), .sc(sc), .tstep(t)
  );

  acc_seq_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) decode_i (
    .ir(ir), .ind(ind), .opd(opd),
    .is_mref(is_mref), .is_rref(is_rref), .is_io(is_io)
  );

  assign ind_ld = t[3] && is_mref && ind;
  assign rr     = t[3] && is_rref;
  assign io     = t[3] && is_io;
  assign rd_dr  = t[4] && (opd[OPC_AND] || opd[OPC_ADD] || opd[OPC_LDA] || opd[OPC_ISZ]);
  assign sta_wr = t[4] && opd[OPC_STA];
  assign bun4   = t[4] && opd[OPC_BUN];
  assign bsa4   = t[4] && opd[OPC_BSA];
  assign bsa5   = t[5] && opd[OPC_BSA];
  assign isz5   = t[5] && opd[OPC_ISZ];
  assign isz6   = t[6] && opd[OPC_ISZ];
  assign acop5  = t[5] && (opd[OPC_AND] || opd[OPC_ADD] || opd[OPC_LDA]);
  assign clr_sc = rr || io || sta_wr || bun4 || bsa5 || acop5 || isz6;
  assign stop   = rr && ir[RB_STOP];

  assign skip = (rr && ((ir[RB_SK_POS] && !ac[DATA_W-1]) ||
                        (ir[RB_SK_NEG] &&  ac[DATA_W-1]) ||
                        (ir[RB_SK_ZAC] && (ac == '0))    ||
                        (ir[RB_SK_ZE]  && !e)))
             || (isz6 && (dr == '0));

  acc_seq_acc #(.DATA_W(DATA_W)) acc_i (
    .clk(clk), .rst_n(rst_n),
    .do_and(t[5] && opd[OPC_AND]),
    .do_add(t[5] && opd[OPC_ADD]),
    .do_lda(t[5] && opd[OPC_LDA]),
    .rr_en(rr),
    .clr_ac(ir[RB_CLR_AC]), .clr_e(ir[RB_CLR_E]),
    .inv_ac(ir[RB_INV_AC]), .inv_e(ir[RB_INV_E]),
    .rot_r(ir[RB_ROT_R]),   .rot_l(ir[RB_ROT_L]),
    .inc_ac(ir[RB_INC_AC]),
    .dr(dr), .ac(ac), .e(e)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc  <= '0;
      ar  <= '0;
      ir  <= '0;
      dr  <= '0;
      ind <= 1'b0;
      run <= 1'b1;
    end else if (run) begin
      if (t[1])              pc <= pc + ONE_A;
      else if (bun4 || bsa5) pc <= ar;
      else if (skip)         pc <= pc + ONE_A;

      if (t[0])        ar <= pc;
      else if (t[2])   ar <= ir[ADDR_W-1:0];
      else if (ind_ld) ar <= mem_rdata[ADDR_W-1:0];
      else if (bsa4)   ar <= ar + ONE_A;

      if (t[1]) ir  <= mem_rdata;
      if (t[2]) ind <= ir[IND_BIT];

      if (rd_dr)     dr <= mem_rdata;
      else if (isz5) dr <= dr + ONE_D;

      if (stop) run <= 1'b0;
    end
  end

  always_comb begin
    mem_wdata = '0;
    if (sta_wr)    mem_wdata = ac;
    else if (bsa4) mem_wdata = {{(DATA_W-ADDR_W){1'b0}}, pc};
    else if (isz6) mem_wdata = dr;
  end

  assign mem_we    = sta_wr || bsa4 || isz6;
  assign mem_addr  = ar;
  assign pc_o      = pc;
  assign ac_o      = ac;
  assign e_o       = e;
  assign step_o    = sc;
  assign running_o = run;
endmodule

// File: rtl/acc_seq_chk.sv
module acc_seq_chk #(
  parameter int ADDR_W = 12,
  parameter int SC_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] pc_o,
  input logic [SC_W-1:0]   step_o,
  input logic              running_o,
  input logic              mem_we
);
  // R11
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o <= SC_W'(6));

  // R11
  write_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (step_o == SC_W'(4) || step_o == SC_W'(6)));

  // R10
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o |=> ($stable(step_o) && $stable(pc_o) && !mem_we));

  // R10
  halt_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running_o) |-> step_o == '0);

  // R3
  fetch_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && step_o == SC_W'(1)) |=> pc_o == $past(pc_o) + ADDR_W'(1));

  // R3
  step_zero_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && step_o == '0) |=> step_o == SC_W'(1));
endmodule

bind acc_seq_core acc_seq_chk #(.ADDR_W(ADDR_W), .SC_W(SC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pc_o(pc_o), .step_o(step_o),
  .running_o(running_o), .mem_we(mem_we)
);

// File: tb/acc_seq_core_tb_top.sv
`timescale 1ns/1ps
module acc_seq_core_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [11:0] mem_addr, pc_o;
  logic [15:0] mem_rdata, mem_wdata, ac_o;
  logic        mem_we, e_o, running_o;
  logic [3:0]  step_o;

  logic [15:0] mem [0:255];
  logic        ld_en = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) begin
    if (mem_we && rst_n) mem[mem_addr[7:0]] <= mem_wdata;
    else if (ld_en)      mem[ld_addr] <= ld_data;
  end

  acc_seq_core dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .pc_o(pc_o), .ac_o(ac_o),
    .e_o(e_o), .step_o(step_o), .running_o(running_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic put(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic wipe();
    rst_n = 1'b0;
    for (int a = 0; a < 64; a++) put(8'(a), 16'h0000);
  endtask

  task automatic run_to_halt(input string req);
    int cyc;
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (running_o && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    check(req, "halt reached", {31'd0, running_o}, 32'd0);
  endtask

  // {ac0, e0, instr, ac1, e1, pc1}
  localparam int NV = 16;
  localparam logic [61:0] VEC [NV] = '{
    {16'h1234, 1'b0, 16'h7800, 16'h0000, 1'b0, 12'h005}, // R8 clear AC
    {16'h1234, 1'b1, 16'h7400, 16'h1234, 1'b0, 12'h005}, // R8 clear E
    {16'h00FF, 1'b0, 16'h7200, 16'hFF00, 1'b0, 12'h005}, // R8 invert AC
    {16'h0001, 1'b0, 16'h7100, 16'h0001, 1'b1, 12'h005}, // R8 invert E
    {16'h0003, 1'b1, 16'h7080, 16'h8001, 1'b1, 12'h005}, // R8 rotate right
    {16'h8000, 1'b0, 16'h7040, 16'h0000, 1'b1, 12'h005}, // R8 rotate left
    {16'hFFFF, 1'b0, 16'h7020, 16'h0000, 1'b0, 12'h005}, // R8 increment
    {16'h0005, 1'b0, 16'h7010, 16'h0005, 1'b0, 12'h006}, // R9 skip pos taken
    {16'h8000, 1'b0, 16'h7010, 16'h8000, 1'b0, 12'h005}, // R9 skip pos not
    {16'h8000, 1'b0, 16'h7008, 16'h8000, 1'b0, 12'h006}, // R9 skip neg taken
    {16'h0000, 1'b0, 16'h7004, 16'h0000, 1'b0, 12'h006}, // R9 skip zero AC
    {16'h0001, 1'b0, 16'h7004, 16'h0001, 1'b0, 12'h005}, // R9 no skip
    {16'h0007, 1'b0, 16'h7002, 16'h0007, 1'b0, 12'h006}, // R9 skip E zero
    {16'h0007, 1'b1, 16'h7002, 16'h0007, 1'b1, 12'h005}, // R9 E set no skip
    {16'h4321, 1'b1, 16'h7000, 16'h4321, 1'b1, 12'h005}, // R8 empty word
    {16'h00FF, 1'b1, 16'hF800, 16'h00FF, 1'b1, 12'h005}  // R2 io class no-op
  };

  initial begin
    #(4 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [11:0] pc_h;
    logic [3:0]  st_h;
    // R1 reset state
    wipe();
    put(8'h00, 16'h2020); put(8'h01, 16'h7001); put(8'h20, 16'h1234);
    check("R1", "pc in reset", {20'd0, pc_o}, 32'h0);
    check("R1", "step in reset", {28'd0, step_o}, 32'h0);
    check("R1", "run in reset", {31'd0, running_o}, 32'h1);
    check("R1", "we in reset", {31'd0, mem_we}, 32'h0);

    // R3 step sequence of a direct LDA
    @(negedge clk);
    rst_n = 1'b1;
    check("R3", "step k0", {28'd0, step_o}, 32'd0);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      check("R3", $sformatf("step k%0d", k), {28'd0, step_o}, (k == 6) ? 32'd0 : k);
      if (k == 1) check("R1", "first fetch address", {20'd0, mem_addr}, 32'h0);
      if (k == 2) check("R3", "pc after fetch", {20'd0, pc_o}, 32'h1);
      if (k == 3) check("R3", "ar from ir", {20'd0, mem_addr}, 32'h20);
    end
    check("R5", "LDA value", {16'd0, ac_o}, 32'h1234);

    // table of register-reference vectors
    for (int i = 0; i < NV; i++) begin
      wipe();
      put(8'h00, 16'h2010);
      put(8'h01, 16'h7400);
      put(8'h02, VEC[i][45] ? 16'h7100 : 16'h7000);
      put(8'h03, VEC[i][44:29]);
      put(8'h04, 16'h7001);
      put(8'h05, 16'h7001);
      put(8'h10, VEC[i][61:46]);
      run_to_halt("R10");
      check((i < 7 || i == 14) ? "R8" : (i == 15 ? "R2" : "R9"),
            $sformatf("vec%0d AC", i), {16'd0, ac_o}, {16'd0, VEC[i][28:13]});
      check((i < 7 || i == 14) ? "R8" : (i == 15 ? "R2" : "R9"),
            $sformatf("vec%0d E", i), {31'd0, e_o}, {31'd0, VEC[i][12]});
      check((i < 7 || i == 14) ? "R8" : (i == 15 ? "R2" : "R9"),
            $sformatf("vec%0d PC", i), {20'd0, pc_o}, {20'd0, VEC[i][11:0]});
    end

    // memory-reference program
    wipe();
    put(8'h00, 16'h2020); put(8'h01, 16'h0021); put(8'h02, 16'h1022);
    put(8'h03, 16'h3023); put(8'h04, 16'hA024); put(8'h05, 16'h4008);
    put(8'h06, 16'h7001); put(8'h08, 16'h5030); put(8'h09, 16'h7001);
    put(8'h31, 16'h6025); put(8'h32, 16'h7001); put(8'h33, 16'h6026);
    put(8'h34, 16'hC030);
    put(8'h20, 16'h00F0); put(8'h21, 16'h0F30); put(8'h22, 16'hFFE0);
    put(8'h24, 16'h0023); put(8'h25, 16'hFFFF); put(8'h26, 16'h0005);
    run_to_halt("R10");
    check("R5", "AND/ADD/indirect LDA result", {16'd0, ac_o}, 32'h0010);
    check("R5", "ADD carry in E", {31'd0, e_o}, 32'h1);
    check("R6", "STA stored", {16'd0, mem[8'h23]}, 32'h0010);
    check("R6", "BSA return word", {16'd0, mem[8'h30]}, 32'h0009);
    check("R7", "ISZ wrap to zero", {16'd0, mem[8'h25]}, 32'h0000);
    check("R7", "ISZ plain increment", {16'd0, mem[8'h26]}, 32'h0006);
    check("R4", "indirect BUN return pc", {20'd0, pc_o}, 32'h00A);

    // R10 frozen while halted
    pc_h = pc_o; st_h = step_o;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (mem_we) check("R10", "write while halted", 32'd1, 32'd0);
    end
    check("R10", "pc frozen", {20'd0, pc_o}, {20'd0, pc_h});
    check("R10", "step frozen", {28'd0, step_o}, {28'd0, st_h});

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule